// File: doc/BRIEF.md
# Parallel EEPROM Page Write Sequencer

This block is the write side of a parallel, page-organised EEPROM, clocked synchronously. It watches the active-low chip-select, write-enable and output-enable strobes. Each qualified write strobe deposits one word into a 64-slot page buffer, and a valid bit marks every slot that has been filled. While the load window is open, the words can arrive in any order and any slot can be written again. The window closes when strobes stop arriving. The block then runs a timed programming phase. At the end of that phase, only the filled slots are copied into a register-based storage array.

A host writes a page by issuing one or more strobes to the same page. It then waits for `busy` to drop. After that it can read any word back through the ordinary read strobes. The block also reports the address and data of the most recent accepted word. Both values hold until the next accepted word.

The controller has three states:
- `ST_IDLE`: no page is open.
- `ST_LOAD`: the window is open.
- `ST_PROG`: the programming phase is running.

It has three transitions:
- *open* (`ST_IDLE`→`ST_LOAD`): the first word is accepted.
- *close* (`ST_LOAD`→`ST_PROG`): the window times out.
- *commit* (`ST_PROG`→`ST_IDLE`): the program timer ends.

Top module: `eeprom_page_writer`

## Requirements
- R1: A cycle counts as write-active only when `cs_n`=0, `we_n`=0 and `oe_n`=1 all hold together. Any other combination inhibits writing.
- R2: A write-active run shorter than `MIN_PULSE` consecutive cycles is discarded. It loads no word and does not re-arm the window timer.
- R3: The address is taken in the first cycle of a write-active run. The data is taken in the last cycle of that run. The word is accepted on the clock edge after the run ends.
- R4: Address bits [5:0] select the slot within the page. Bits [ADDR_W-1:6] form the page number. The first accepted word after `ST_IDLE` fixes the page number for the whole window.
- R5: A word whose page number differs from the open page is dropped. It does not change the buffer, `last_addr` or `last_data`.
- R6: Slots may be loaded in any order. A slot written twice in one window keeps the later data.
- R7: The window closes, and *close* is taken, once more than `LOAD_WIN` cycles have passed since the latest qualified strobe start while no strobe is active. A strobe start is qualified on its `MIN_PULSE`-th active cycle.
- R8: `ST_PROG` lasts exactly `PROG_CYC` cycles. At *commit*, only the filled slots are written to the array. Slots that were not loaded keep their earlier contents.
- R9: Write strobes that end while the state is `ST_PROG` are ignored. Strobe starts in `ST_PROG` do not re-arm the window timer.
- R10: `busy` is 1 from the edge that accepts the first word until the *commit* edge. `last_addr` and `last_data` show the most recent accepted word.
- R11: A cycle with `cs_n`=0, `oe_n`=0 and `we_n`=1 loads the array word at `addr` into `rd_data` on the next edge. Any other cycle loads 0.
- R12: After reset, `busy`, `last_addr`, `last_data` and `rd_data` are 0, and every array word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address: page number above slot index |
| din | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data, 0 when not reading |
| busy | output | 1 | Page open or programming |
| last_addr | output | ADDR_W | Address of the most recent accepted word |
| last_data | output | DATA_W | Data of the most recent accepted word |

## Verification
The checker verifies the following on every cycle:
- the read output is zero outside read cycles;
- the page number of `last_addr` holds for as long as `busy` stays high;
- the reported word stays frozen throughout `ST_PROG`;
- `busy` rises only two edges after a write-active cycle;
- `busy` falls only after exactly `PROG_CYC` programming cycles.

Some behaviours need the bench's behavioural model and its directed scenarios:
- rewritten slots keep the later data;
- unloaded slots are left untouched;
- short strobes and inhibited strobe combinations are discarded;
- words for a foreign page, or words arriving during programming, are dropped;
- the window timeout edge is exact.

// File: rtl/eew_pkg.sv
package eew_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } eew_state_e;
endpackage

// File: rtl/eew_strobe.sv
module eew_strobe #(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 8,
    parameter int MIN_PULSE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              active,
    output logic              start_q,
    output logic              load_v,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [DATA_W-1:0] ld_data
);
    localparam int CW = $clog2(MIN_PULSE + 1);

    logic          act_q;
    logic [CW-1:0] run_q;

    assign active  = !cs_n && !we_n && oe_n;
    assign start_q = active && (run_q == CW'(MIN_PULSE - 1));
    assign load_v  = !active && act_q && (run_q == CW'(MIN_PULSE));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            run_q   <= '0;
            ld_addr <= '0;
            ld_data <= '0;
        end else begin
            act_q <= active;
            if (active) begin
                if (!act_q) ld_addr <= addr;
                ld_data <= din;
                if (run_q < CW'(MIN_PULSE)) run_q <= run_q + 1'b1;
            end else begin
                run_q <= '0;
            end
        end
    end
endmodule

// File: rtl/eew_page_buf.sv
module eew_page_buf #(
    parameter int DATA_W = 8,
    parameter int OFFS_W = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [OFFS_W-1:0]                wr_off,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic                             clr,
    output logic [(1<<OFFS_W)-1:0]           slot_vld,
    output logic [(1<<OFFS_W)*DATA_W-1:0]    slot_data
);
    localparam int WORDS = 1 << OFFS_W;

    for (genvar g = 0; g < WORDS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                slot_vld[g]                     <= 1'b0;
                slot_data[g*DATA_W +: DATA_W]   <= '0;
            end else if (wr_en && wr_off == OFFS_W'(g)) begin
                slot_vld[g]                     <= 1'b1;
                slot_data[g*DATA_W +: DATA_W]   <= wr_data;
            end
        end
    end
endmodule

// File: rtl/eew_array.sv
module eew_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int OFFS_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit,
    input  logic [ADDR_W-OFFS_W-1:0]      commit_page,
    input  logic [(1<<OFFS_W)-1:0]        slot_vld,
    input  logic [(1<<OFFS_W)*DATA_W-1:0] slot_data,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data
);
    localparam int WORDS = 1 << OFFS_W;
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rd_data <= '0;
        end else begin
            rd_data <= rd_en ? mem[rd_addr] : '0;
            if (commit) begin
                for (int i = 0; i < WORDS; i++) begin
                    if (slot_vld[i])
                        mem[{commit_page, OFFS_W'(i)}] <= slot_data[i*DATA_W +: DATA_W];
                end
            end
        end
    end
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 8,
    parameter int OFFS_W    = 6,
    parameter int MIN_PULSE = 3,
    parameter int LOAD_WIN  = 30000,
    parameter int PROG_CYC  = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic [ADDR_W-1:0] last_addr,
    output logic [DATA_W-1:0] last_data
);
    import eew_pkg::*;

    localparam int WORDS  = 1 << OFFS_W;
    localparam int PAGE_W = ADDR_W - OFFS_W;
    localparam int TMAX   = (LOAD_WIN > PROG_CYC) ? LOAD_WIN : PROG_CYC;
    localparam int TW     = $clog2(TMAX + 1);

    eew_state_e          state_q, state_d;
    logic [TW-1:0]       tick_q;
    logic [PAGE_W-1:0]   page_q;
    logic                active, start_q, load_v;
    logic [ADDR_W-1:0]   ld_addr;
    logic [DATA_W-1:0]   ld_data;
    logic [WORDS-1:0]    slot_vld;
    logic [WORDS*DATA_W-1:0] slot_data;
    logic                accept, win_done, prog_done, rd_en, prog_active;

    eew_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)) u_strobe (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .active(active), .start_q(start_q),
        .load_v(load_v), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    eew_page_buf #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_off(ld_addr[OFFS_W-1:0]),
        .wr_data(ld_data), .clr(prog_done), .slot_vld(slot_vld), .slot_data(slot_data)
    );

    eew_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(OFFS_W)) u_array (
        .clk(clk), .rst_n(rst_n), .commit(prog_done), .commit_page(page_q),
        .slot_vld(slot_vld), .slot_data(slot_data), .rd_en(rd_en),
        .rd_addr(addr), .rd_data(rd_data)
    );

    assign rd_en       = !cs_n && !oe_n && we_n;
    assign accept      = load_v && (state_q != ST_PROG) &&
                         ((state_q == ST_IDLE) || (ld_addr[ADDR_W-1:OFFS_W] == page_q));
    assign win_done    = (state_q == ST_LOAD) && !active && (tick_q >= TW'(LOAD_WIN));
    assign prog_done   = (state_q == ST_PROG) && (tick_q == TW'(PROG_CYC - 1));
    assign busy        = (state_q != ST_IDLE);
    assign prog_active = (state_q == ST_PROG);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: open, close, commit
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)    state_d = ST_LOAD;
            ST_LOAD: if (win_done)  state_d = ST_PROG;
            ST_PROG: if (prog_done) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // Timer, page and reported word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q    <= '0;
            page_q    <= '0;
            last_addr <= '0;
            last_data <= '0;
        end else begin
            if (win_done)
                tick_q <= '0;
            else if (start_q && state_q != ST_PROG)
                tick_q <= '0;
            else if (tick_q < TW'(TMAX))
                tick_q <= tick_q + 1'b1;
            if (accept) begin
                last_addr <= ld_addr;
                last_data <= ld_data;
                if (state_q == ST_IDLE) page_q <= ld_addr[ADDR_W-1:OFFS_W];
            end
        end
    end
endmodule

// File: rtl/eew_checker.sv
module eew_checker #(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 8,
    parameter int OFFS_W   = 6,
    parameter int PROG_CYC = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              busy,
    input logic              in_prog,
    input logic [ADDR_W-1:0] last_addr,
    input logic [DATA_W-1:0] last_data,
    input logic [DATA_W-1:0] rd_data
);
    localparam int PW = $clog2(PROG_CYC + 2);
    logic [PW-1:0] prog_run;

    always_ff @(posedge clk) begin
        if (!rst_n || !in_prog) prog_run <= '0;
        else if (prog_run < PW'(PROG_CYC + 1)) prog_run <= prog_run + 1'b1;
    end

    assert_rd_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!cs_n && !oe_n && we_n) |=> (rd_data == '0));

    assert_page_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (last_addr[ADDR_W-1:OFFS_W] == $past(last_addr[ADDR_W-1:OFFS_W])));

    assert_prog_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_prog |=> ($stable(last_addr) && $stable(last_data)));

    assert_busy_from_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!cs_n && !we_n && oe_n, 2));

    assert_prog_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (prog_run == PW'(PROG_CYC)));
endmodule

bind eeprom_page_writer eew_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(OFFS_W), .PROG_CYC(PROG_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .busy(busy), .in_prog(prog_active), .last_addr(last_addr),
    .last_data(last_data), .rd_data(rd_data)
);

// File: tb/eeprom_page_writer_tb.sv
`timescale 1ns/1ps
module eeprom_page_writer_tb;
    localparam int AW = 10, DW = 8, OW = 6, MP = 3, LW = 20, PC = 30;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] rd_data, last_data;
    logic [AW-1:0] last_addr;
    logic busy;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    eeprom_page_writer #(.ADDR_W(AW), .DATA_W(DW), .OFFS_W(OW), .MIN_PULSE(MP),
        .LOAD_WIN(LW), .PROG_CYC(PC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .rd_data(rd_data), .busy(busy),
        .last_addr(last_addr), .last_data(last_data));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Behavioural reference model
    logic [DW-1:0] m_mem [DEPTH];
    logic [DW-1:0] m_bd [64];
    bit            m_bv [64];
    int  cyc, last_start, prog_start, run, mst, m_page;
    int  ma, md, e_rd, e_la, e_ld;

    always @(posedge clk) begin
        bit act, rd;
        int os;
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
            for (int i = 0; i < 64; i++) begin m_bv[i] = 0; m_bd[i] = '0; end
            cyc = 0; last_start = 0; prog_start = 0; run = 0; mst = 0; m_page = 0;
            ma = 0; md = 0; e_rd = 0; e_la = 0; e_ld = 0;
        end else begin
            cyc++;
            act = !cs_n && !we_n && oe_n;
            rd  = !cs_n && !oe_n && we_n;
            os  = mst;
            e_rd = rd ? int'(m_mem[addr]) : 0;
            if (!act && run >= MP && os != 2) begin
                if (os == 0 || (ma >> OW) == m_page) begin
                    if (os == 0) begin m_page = ma >> OW; mst = 1; end
                    m_bv[ma % 64] = 1; m_bd[ma % 64] = DW'(md);
                    e_la = ma; e_ld = md;
                end
            end
            if (act) begin
                if (run == 0) ma = int'(addr);
                md = int'(din);
                run++;
                if (run == MP && os != 2) last_start = cyc;
            end else run = 0;
            if (os == 1 && !act && (cyc - 1 - last_start) >= LW) begin
                mst = 2; last_start = cyc; prog_start = cyc;
            end
            if (os == 2 && (cyc - prog_start) == PC) begin
                for (int i = 0; i < 64; i++) begin
                    if (m_bv[i]) m_mem[m_page * 64 + i] = m_bd[i];
                    m_bv[i] = 0;
                end
                mst = 0;
            end
        end
        #2;
        if (rst_n) begin
            chk("R10 busy", busy, mst != 0);
            chk("R10 last_addr", last_addr, e_la);
            chk("R10 last_data", last_data, e_ld);
            chk("R11 rd_data", rd_data, e_rd);
        end
    end

    task automatic wr(input int a, input int d, input int len);
        @(negedge clk);
        addr = AW'(a); din = DW'(d); cs_n = 0; we_n = 0; oe_n = 1;
        repeat (len - 1) @(negedge clk);
        @(negedge clk);
        cs_n = 1; we_n = 1;
        repeat (2) @(negedge clk);
    endtask

    task automatic rdchk(input string tag, input int a, input int exp);
        @(negedge clk);
        addr = AW'(a); cs_n = 0; oe_n = 0; we_n = 1;
        @(posedge clk); #2;
        chk(tag, rd_data, exp);
        @(negedge clk);
        cs_n = 1; oe_n = 1;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 500 && busy; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk("R12 busy", busy, 0);
        chk("R12 last_addr", last_addr, 0);
        chk("R12 rd_data", rd_data, 0);
        rdchk("R12 array zero", 10'h155, 0);

        // R8 single word, page 2 slot 5
        wr(2*64 + 5, 8'hA5, 3);
        chk("R10 busy after load", busy, 1);
        chk("R3 last_addr", last_addr, 2*64 + 5);
        wait_idle();
        rdchk("R8 single word", 2*64 + 5, 8'hA5);
        rdchk("R8 neighbour untouched", 2*64 + 6, 0);

        // R6 out of order, rewrite; R5 foreign page
        wr(3*64 + 10, 8'h11, 3);
        wr(3*64 + 3,  8'h22, 4);
        wr(5*64 + 3,  8'h99, 3);   // foreign page, dropped
        chk("R5 last kept", last_addr, 3*64 + 3);
        wr(3*64 + 10, 8'h33, 3);
        wr(3*64 + 63, 8'h44, 5);
        wr(3*64 + 0,  8'h55, 3);
        // R7 window still open after loads spaced below LOAD_WIN
        repeat (10) @(negedge clk);
        chk("R7 window open", busy, 1);
        wait_idle();
        rdchk("R6 rewrite later wins", 3*64 + 10, 8'h33);
        rdchk("R6 slot 3", 3*64 + 3, 8'h22);
        rdchk("R4 slot 63", 3*64 + 63, 8'h44);
        rdchk("R4 slot 0", 3*64 + 0, 8'h55);
        rdchk("R8 unloaded slot", 3*64 + 7, 0);
        rdchk("R5 foreign page dropped", 5*64 + 3, 0);

        // R2 short pulse
        wr(64 + 1, 8'h77, 2);
        chk("R2 short pulse no busy", busy, 0);
        // R1 inhibited: oe low during write strobes
        @(negedge clk); addr = 10'd70; din = 8'h66; cs_n = 0; we_n = 0; oe_n = 0;
        repeat (4) @(negedge clk); cs_n = 1; we_n = 1; oe_n = 1;
        repeat (2) @(negedge clk);
        chk("R1 oe low inhibits", busy, 0);
        // R1 cs high inhibits
        @(negedge clk); addr = 10'd71; cs_n = 1; we_n = 0; oe_n = 1;
        repeat (4) @(negedge clk); we_n = 1;
        repeat (2) @(negedge clk);
        chk("R1 cs high inhibits", busy, 0);
        rdchk("R2 short pulse not written", 64 + 1, 0);

        // R3 address from first cycle, data from last; we first then cs last
        @(negedge clk); addr = AW'(6*64 + 9); din = 8'h01; we_n = 0; oe_n = 1;
        @(negedge clk); cs_n = 0;
        @(negedge clk); addr = AW'(6*64 + 20); din = 8'h02;
        @(negedge clk); din = 8'h03;
        @(negedge clk); cs_n = 1; we_n = 1;
        repeat (2) @(negedge clk);
        chk("R3 addr first cycle", last_addr, 6*64 + 9);
        chk("R3 data last cycle", last_data, 8'h03);

        // R9 strobes during programming ignored
        for (int i = 0; i < 200 && !u_dut_busy_prog(); i++) @(negedge clk);
        wr(6*64 + 30, 8'hEE, 3);
        chk("R9 last unchanged", last_addr, 6*64 + 9);
        wait_idle();
        rdchk("R3 word committed", 6*64 + 9, 8'h03);
        rdchk("R9 ignored word", 6*64 + 30, 0);

        repeat (5) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Programming phase seen from the ports: busy with LOAD_WIN elapsed and no strobes
    int idle_cnt = 0;
    always @(negedge clk) idle_cnt = (busy && cs_n) ? idle_cnt + 1 : 0;
    function automatic bit u_dut_busy_prog();
        return idle_cnt > LW + 3;
    endfunction
endmodule